// File: doc/BRIEF.md
# Host-to-Guest Mailbox Bus Master

This block is a single 32-bit mailbox register that lets a host run one-byte transfers to as many as eight small peripherals on an 8-bit parallel guest bus. The host fills in a direction bit, a guest number and a guest register index. When it writes the data byte, the block runs a bus cycle. During the cycle it pulls low the chip select of the chosen guest and drives the register index on the address lines. It then waits for the guest to release its active-low wait line and finishes the cycle.

On a read the guest's byte is captured into the data field. On a write the data field is driven onto the bus. Two flags report the state of the mailbox. The pending flag is high while a cycle is queued or running. The sticky timeout flag is set when a guest stretches a cycle past 64 clocks. Status and configuration share one register, and host writes go through per-byte enables.

Top module: `mbox_guest_master`

## Requirements
- R1: The register reads back as follows: bit 25 pending, bit 24 timeout, bit 23 direction, bits 22:20 guest number, bits 18:16 register index, bits 7:0 data. Every other bit reads 0. After reset the direction is 1 and every other field is 0, so the register reads 0x0080_0000.
- R2: A host write with byte enable 0 set, while pending is 0, loads bits 7:0 into the data field, sets pending and starts a bus cycle. Pending returns to 0 when the cycle completes or times out.
- R3: If a host write with byte enable 0 lands on the same clock as the clear at the end of a cycle, pending ends at 0 and no new cycle starts.
- R4: While a cycle is running, exactly one bit of `gb_cs_n` is low, the bit whose index is the guest number. `gb_addr` carries the register index. All selects are high outside a cycle.
- R5: Direction 1 is a write cycle: `gb_wr_n` is low, `gb_wdata_oe` is high and `gb_wdata` holds the data field. Direction 0 is a read cycle: `gb_rd_n` is low.
- R6: On a read cycle, `gb_rdata` is stored into the data field on the clock edge at which `gb_wait_n` is seen high in the wait phase.
- R7: The chip select stays low for one address clock plus wait clocks, until `gb_wait_n` is high. It is then released one clock after completion. A guest that releases the wait line on the 64th select clock completes normally.
- R8: If `gb_wait_n` is still low on the 64th select clock, the cycle is aborted. The select rises on the next clock, the timeout flag sets, pending clears and the data field keeps its value.
- R9: The timeout flag is cleared only by a host write with byte enable 3 set and bit 24 equal to 1. A 0 in bit 24 has no effect. A new timeout on the same clock as a clear leaves the flag at 1.
- R10: While pending is 1, host writes to the direction, guest number, register index and data fields (byte enables 2 and 0) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| host_wr_en | input | 1 | Host write strobe, one clock |
| host_wr_be | input | 4 | Byte enables: 3 timeout clear, 2 configuration, 0 data and start |
| host_wr_data | input | 32 | Host write data |
| host_rd_data | output | 32 | Register read value |
| gb_cs_n | output | 8 | Active-low chip select per guest |
| gb_addr | output | 3 | Guest register address |
| gb_wr_n | output | 1 | Active-low write strobe |
| gb_rd_n | output | 1 | Active-low read strobe |
| gb_wdata | output | 8 | Write data to the guest |
| gb_wdata_oe | output | 1 | Write data drive enable |
| gb_rdata | input | 8 | Read data from the guest |
| gb_wait_n | input | 1 | Guest wait line, low stretches the cycle |

## Verification
The cases that are hardest to reach from the ports are the two same-clock collisions. The first is a host data write landing exactly on a cycle's completion edge. The second is a timeout-clear write landing exactly on the edge where the 64-clock limit expires. The bench's guest model releases its wait line after a chosen number of select clocks, so the completion edge and the abort edge can be counted from the starting write. The colliding write is driven for exactly that edge. The wait holds of 63 and 64 clocks bracket the timeout boundary.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int DATA_W   = 8;
  localparam int REG_W    = 32;
  localparam int POS_PEND = 25;
  localparam int POS_TMO  = 24;
  localparam int POS_DIR  = 23;
  localparam int POS_GID  = 20;
  localparam int POS_GREG = 16;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ASSERT = 2'd1,
    ST_WAIT   = 2'd2,
    ST_DONE   = 2'd3
  } cyc_state_e;
endpackage

// File: rtl/mbox_tmo_ctr.sv
module mbox_tmo_ctr #(
  parameter int TMO_CLKS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(TMO_CLKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TMO_CLKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)
      cnt_d = '0;
    else if (cnt_q != LAST)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // counts select clocks: 0 on the address clock, so LAST marks the final allowed clock
  assign expire = run && (cnt_q == LAST);

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  p_cnt_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);
endmodule

// File: rtl/mbox_regs.sv
module mbox_regs
  import mbox_pkg::*;
#(
  parameter int IDW = 3,
  parameter int AW  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_be,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              cyc_end,
  input  logic              tmo_evt,
  input  logic              rd_capture,
  input  logic [DATA_W-1:0] gb_rdata,
  output logic              pend,
  output logic              dir,
  output logic [IDW-1:0]    gid,
  output logic [AW-1:0]     greg,
  output logic [DATA_W-1:0] data,
  output logic [REG_W-1:0]  rd_data
);
  logic              pend_d, tmo_q, tmo_d, dir_d;
  logic [IDW-1:0]    gid_d;
  logic [AW-1:0]     greg_d;
  logic [DATA_W-1:0] data_d;
  logic start_wr, cfg_wr, tmo_clr, pend_clr;

  assign start_wr = wr_en && wr_be[0];
  assign cfg_wr   = wr_en && wr_be[2] && !pend;
  assign tmo_clr  = wr_en && wr_be[3] && wr_data[POS_TMO];
  assign pend_clr = cyc_end || tmo_evt;

  always_comb begin
    // clear beats set on a collision
    pend_d = pend;
    if (pend_clr)      pend_d = 1'b0;
    else if (start_wr) pend_d = 1'b1;

    // set beats clear on a collision
    tmo_d = tmo_q;
    if (tmo_evt)      tmo_d = 1'b1;
    else if (tmo_clr) tmo_d = 1'b0;

    dir_d  = dir;
    gid_d  = gid;
    greg_d = greg;
    if (cfg_wr) begin
      dir_d  = wr_data[POS_DIR];
      gid_d  = wr_data[POS_GID +: IDW];
      greg_d = wr_data[POS_GREG +: AW];
    end

    data_d = data;
    if (rd_capture)             data_d = gb_rdata;
    else if (start_wr && !pend) data_d = wr_data[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      tmo_q <= 1'b0;
      dir   <= 1'b1;
      gid   <= '0;
      greg  <= '0;
      data  <= '0;
    end else begin
      pend  <= pend_d;
      tmo_q <= tmo_d;
      dir   <= dir_d;
      gid   <= gid_d;
      greg  <= greg_d;
      data  <= data_d;
    end
  end

  always_comb begin
    rd_data                      = '0;
    rd_data[POS_PEND]            = pend;
    rd_data[POS_TMO]             = tmo_q;
    rd_data[POS_DIR]             = dir;
    rd_data[POS_GID +: IDW]      = gid;
    rd_data[POS_GREG +: AW]      = greg;
    rd_data[DATA_W-1:0]          = data;
  end

  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_data[REG_W-1:POS_TMO+1], wr_data[POS_GREG-1:DATA_W], wr_be[1]};

  p_pend_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pend_clr |=> !pend);
  p_tmo_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> tmo_q);
  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> $stable({dir, gid, greg}));
endmodule

// File: rtl/mbox_cycle_fsm.sv
module mbox_cycle_fsm
  import mbox_pkg::*;
#(
  parameter int NUM_GUESTS = 8,
  parameter int IDW = 3,
  parameter int AW  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pend,
  input  logic                  dir,
  input  logic [IDW-1:0]        gid,
  input  logic [AW-1:0]         greg,
  input  logic [DATA_W-1:0]     data,
  input  logic                  gb_wait_n,
  input  logic                  expire,
  output logic                  run,
  output logic                  cyc_end,
  output logic                  tmo_evt,
  output logic                  rd_capture,
  output logic [NUM_GUESTS-1:0] gb_cs_n,
  output logic [AW-1:0]         gb_addr,
  output logic                  gb_wr_n,
  output logic                  gb_rd_n,
  output logic [DATA_W-1:0]     gb_wdata,
  output logic                  gb_wdata_oe
);
  cyc_state_e st_q, st_d;

  always_comb begin
    st_d    = st_q;
    cyc_end = 1'b0;
    tmo_evt = 1'b0;
    unique case (st_q)
      ST_IDLE:   if (pend) st_d = ST_ASSERT;
      ST_ASSERT: st_d = ST_WAIT;
      ST_WAIT: begin
        if (gb_wait_n) begin
          st_d    = ST_DONE;
          cyc_end = 1'b1;
        end else if (expire) begin
          st_d    = ST_IDLE;
          tmo_evt = 1'b1;
        end
      end
      ST_DONE:   st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign run        = (st_q == ST_ASSERT) || (st_q == ST_WAIT);
  assign rd_capture = cyc_end && !dir;

  for (genvar g = 0; g < NUM_GUESTS; g++) begin : g_cs
    assign gb_cs_n[g] = !(run && (gid == IDW'(g)));
  end

  assign gb_addr     = greg;
  assign gb_wr_n     = !(run && dir);
  assign gb_rd_n     = !(run && !dir);
  assign gb_wdata    = data;
  assign gb_wdata_oe = run && dir;

  p_cs_onehot0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~gb_cs_n));
  p_cs_needs_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(&gb_cs_n) |-> pend);
  p_done_after_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && gb_wait_n) |=> (st_q == ST_DONE && &gb_cs_n));
  p_abort_drops_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> &gb_cs_n);
endmodule

// File: rtl/mbox_guest_master.sv
module mbox_guest_master
  import mbox_pkg::*;
#(
  parameter int NUM_GUESTS = 8,
  parameter int NUM_GREGS  = 8,
  parameter int TMO_CLKS   = 64
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            host_wr_en,
  input  logic [3:0]                      host_wr_be,
  input  logic [31:0]                     host_wr_data,
  output logic [31:0]                     host_rd_data,
  output logic [NUM_GUESTS-1:0]           gb_cs_n,
  output logic [$clog2(NUM_GREGS)-1:0]    gb_addr,
  output logic                            gb_wr_n,
  output logic                            gb_rd_n,
  output logic [7:0]                      gb_wdata,
  output logic                            gb_wdata_oe,
  input  logic [7:0]                      gb_rdata,
  input  logic                            gb_wait_n
);
  localparam int IDW = $clog2(NUM_GUESTS);
  localparam int AW  = $clog2(NUM_GREGS);

  logic              pend, dir, run, cyc_end, tmo_evt, rd_capture, expire;
  logic [IDW-1:0]    gid;
  logic [AW-1:0]     greg;
  logic [DATA_W-1:0] data;

  mbox_regs #(.IDW(IDW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(host_wr_en), .wr_be(host_wr_be), .wr_data(host_wr_data),
    .cyc_end(cyc_end), .tmo_evt(tmo_evt), .rd_capture(rd_capture),
    .gb_rdata(gb_rdata),
    .pend(pend), .dir(dir), .gid(gid), .greg(greg), .data(data),
    .rd_data(host_rd_data)
  );

  mbox_tmo_ctr #(.TMO_CLKS(TMO_CLKS)) u_tmo (
    .clk(clk), .rst_n(rst_n), .run(run), .expire(expire)
  );

  mbox_cycle_fsm #(.NUM_GUESTS(NUM_GUESTS), .IDW(IDW), .AW(AW)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .pend(pend), .dir(dir), .gid(gid), .greg(greg), .data(data),
    .gb_wait_n(gb_wait_n), .expire(expire),
    .run(run), .cyc_end(cyc_end), .tmo_evt(tmo_evt), .rd_capture(rd_capture),
    .gb_cs_n(gb_cs_n), .gb_addr(gb_addr), .gb_wr_n(gb_wr_n), .gb_rd_n(gb_rd_n),
    .gb_wdata(gb_wdata), .gb_wdata_oe(gb_wdata_oe)
  );
endmodule

// File: tb/mbox_guest_master_tb_top.sv
module mbox_guest_master_tb_top;
  logic        clk, rst_n;
  logic        host_wr_en;
  logic [3:0]  host_wr_be;
  logic [31:0] host_wr_data, host_rd_data;
  logic [7:0]  gb_cs_n;
  logic [2:0]  gb_addr;
  logic        gb_wr_n, gb_rd_n, gb_wdata_oe, gb_wait_n;
  logic [7:0]  gb_wdata, gb_rdata;

  int n_chk, n_fail;
  int hold_clks, act_cnt, last_len;
  logic [2:0] obs_id, obs_addr;
  logic       obs_wr, obs_rd;
  logic [7:0] obs_wdata;
  bit         done_flag;

  mbox_guest_master dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en(host_wr_en), .host_wr_be(host_wr_be), .host_wr_data(host_wr_data),
    .host_rd_data(host_rd_data),
    .gb_cs_n(gb_cs_n), .gb_addr(gb_addr), .gb_wr_n(gb_wr_n), .gb_rd_n(gb_rd_n),
    .gb_wdata(gb_wdata), .gb_wdata_oe(gb_wdata_oe),
    .gb_rdata(gb_rdata), .gb_wait_n(gb_wait_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] guest_byte(input logic [2:0] id, input logic [2:0] a);
    return {id, a, 2'b01} ^ 8'hC3;
  endfunction

  function automatic logic [2:0] cs_index(input logic [7:0] csn);
    logic [2:0] r = '0;
    for (int g = 7; g >= 0; g--) if (!csn[g]) r = 3'(g);
    return r;
  endfunction

  assign gb_rdata = guest_byte(cs_index(gb_cs_n), gb_addr);

  // guest model: hold wait low for hold_clks select clocks
  always @(negedge clk) begin
    if (!(&gb_cs_n)) begin
      act_cnt   = act_cnt + 1;
      obs_id    = cs_index(gb_cs_n);
      obs_addr  = gb_addr;
      obs_wr    = !gb_wr_n;
      obs_rd    = !gb_rd_n;
      if (!gb_wr_n && gb_wdata_oe) obs_wdata = gb_wdata;
      gb_wait_n = (act_cnt > hold_clks);
    end else begin
      if (act_cnt != 0) last_len = act_cnt;
      act_cnt   = 0;
      gb_wait_n = 1'b1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    host_wr_en = 1'b1; host_wr_be = be; host_wr_data = d;
    @(negedge clk);
    host_wr_en = 1'b0; host_wr_be = '0; host_wr_data = '0;
  endtask

  task automatic wait_idle();
    int k = 0;
    while (host_rd_data[25] && k < 300) begin @(negedge clk); k++; end
    chk("R2 pending clears", {31'b0, host_rd_data[25]}, 32'd0);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [31:0] word(input logic d, input logic [2:0] id,
                                       input logic [2:0] a, input logic [7:0] b);
    return {8'b0, d, id, 1'b0, a, 8'b0, b};
  endfunction

  // vector: dir, id, reg, data, hold
  localparam int NV = 8;
  localparam logic [22:0] VEC [NV] = '{
    {1'b1, 3'd0, 3'd0, 8'hA5, 8'd0},
    {1'b1, 3'd7, 3'd7, 8'h3C, 8'd5},
    {1'b0, 3'd3, 3'd5, 8'h44, 8'd0},
    {1'b0, 3'd6, 3'd2, 8'h12, 8'd63},
    {1'b0, 3'd1, 3'd4, 8'h77, 8'd64},
    {1'b1, 3'd2, 3'd1, 8'h81, 8'd64},
    {1'b1, 3'd5, 3'd6, 8'h0F, 8'd1},
    {1'b0, 3'd4, 3'd3, 8'h99, 8'd10}
  };

  initial begin
    #(5.0 * 100000);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done_flag = 0;
    hold_clks = 0; act_cnt = 0; last_len = 0;
    obs_id = '0; obs_addr = '0; obs_wr = 0; obs_rd = 0; obs_wdata = '0;
    gb_wait_n = 1'b1;
    host_wr_en = 0; host_wr_be = '0; host_wr_data = '0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 reset value", host_rd_data, 32'h0080_0000);
    chk("R4 selects idle", {24'b0, gb_cs_n}, 32'hFF);
    chk("R5 strobes idle", {30'b0, gb_wr_n, gb_rd_n}, 32'd3);

    for (int v = 0; v < NV; v++) begin
      logic d; logic [2:0] id, a; logic [7:0] b; int h; bit to;
      logic [7:0] exp_data; int exp_len;
      d = VEC[v][22]; id = VEC[v][21:19]; a = VEC[v][18:16];
      b = VEC[v][15:8]; h = int'(VEC[v][7:0]);
      to = (h >= 64);
      exp_len  = to ? 64 : ((h + 1 > 2) ? h + 1 : 2);
      exp_data = (d || to) ? b : guest_byte(id, a);
      hold_clks = h;
      host_wr(4'b0101, word(d, id, a, b));
      chk("R2 pending set", {31'b0, host_rd_data[25]}, 32'd1);
      wait_idle();
      chk("R1 readback", host_rd_data,
          {6'b0, 1'b0, to, d, id, 1'b0, a, 8'b0, exp_data});
      chk("R6 R8 data field", {24'b0, host_rd_data[7:0]}, {24'b0, exp_data});
      chk("R7 R8 select length", last_len, exp_len);
      chk("R4 select index", {29'b0, obs_id}, {29'b0, id});
      chk("R4 address", {29'b0, obs_addr}, {29'b0, a});
      chk("R5 strobe kind", {30'b0, obs_wr, obs_rd}, {30'b0, d, !d});
      if (d) chk("R5 write data", {24'b0, obs_wdata}, {24'b0, b});
      if (to) begin
        host_wr(4'b1000, 32'h0);
        chk("R9 zero write keeps timeout", {31'b0, host_rd_data[24]}, 32'd1);
        host_wr(4'b1000, 32'h0100_0000);
        chk("R9 clear", {31'b0, host_rd_data[24]}, 32'd0);
      end
    end

    // R10 writes during pending ignored
    hold_clks = 10;
    host_wr(4'b0101, word(1'b0, 3'd2, 3'd3, 8'h11));
    host_wr(4'b0101, word(1'b1, 3'd6, 3'd0, 8'hEE));
    wait_idle();
    chk("R10 config kept", host_rd_data,
        {8'b0, 1'b0, 3'd2, 1'b0, 3'd3, 8'b0, guest_byte(3'd2, 3'd3)});
    chk("R10 guest unchanged", {29'b0, obs_id}, 32'd2);

    // R3 start write collides with completion edge (hold 0: done 3 edges after start)
    hold_clks = 0;
    host_wr(4'b0101, word(1'b1, 3'd4, 3'd1, 8'h5A));
    @(negedge clk);
    host_wr(4'b0001, 32'h0000_00C7);
    chk("R3 collision pending 0", {31'b0, host_rd_data[25]}, 32'd0);
    repeat (4) begin
      @(negedge clk);
      chk("R3 no new cycle", {24'b0, gb_cs_n}, 32'hFF);
    end
    chk("R3 data kept", {24'b0, host_rd_data[7:0]}, 32'h5A);

    // R9 clear collides with timeout edge (64 edges after the address clock starts)
    hold_clks = 200;
    host_wr(4'b0101, word(1'b0, 3'd5, 3'd2, 8'h33));
    repeat (63) @(negedge clk);
    chk("R8 select held before limit", {31'b0, gb_cs_n[5]}, 32'd0);
    host_wr(4'b1000, 32'h0100_0000);
    chk("R9 set wins over clear", {31'b0, host_rd_data[24]}, 32'd1);
    chk("R8 select dropped", {24'b0, gb_cs_n}, 32'hFF);
    chk("R8 data unchanged", {24'b0, host_rd_data[7:0]}, 32'h33);
    host_wr(4'b1000, 32'h0100_0000);
    chk("R9 clear after collision", {31'b0, host_rd_data[24]}, 32'd0);

    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule